// File: doc/BRIEF.md
# Dual-Read Register Bank with Asymmetric Bypass

This block is a small general-purpose register file. It holds eight 16-bit words. It has one write port and two independent read ports. A write is committed on a rising clock edge when the write-enable is high. Each read port takes a register number at a rising edge and presents that register's word on its output just after the edge. The output stays there until the next edge.

Register 0 is a hard zero. Writes aimed at it are dropped, and any read of it returns zero. The two read ports differ on purpose when one of them reads the register that is being written at the same edge. The first port returns the word held before the write. The second port returns the incoming write data. A consumer can therefore pick, per operand, whether it wants pre-write or post-write semantics.

A synchronous, active-high reset clears registers 1 to 7 and both read outputs.

Top module: `dual_read_regbank`

## Requirements
- R1: With `wr_en` high at a rising edge and `wr_sel` between 1 and 7, `wr_data` is stored in that register, and a later read of it on either port returns that word.
- R2: Reading register number 0 (`rd1_sel` or `rd2_sel` equal to 3'd0) returns 16'h0000 on that port, and a write with `wr_sel` equal to 3'd0 changes no register.
- R3: At a rising edge with `wr_en` low, no register changes, whatever `wr_sel` and `wr_data` are.
- R4: With `rst` high at a rising edge, registers 1 to 7 become zero and both `rd1_data` and `rd2_data` read 16'h0000 after that edge.
- R5: When `rd1_sel` names the register being written at the same edge, `rd1_data` shows the value the register held before that write.
- R6: When `rd2_sel` names the register being written at the same edge, `rd2_data` shows the new `wr_data`.
- R7: Port 2 forwards `wr_data` only when `wr_en` is high and `wr_sel` is nonzero. With `wr_en` low it returns the stored word, and with `wr_sel` equal to 0 and `rd2_sel` equal to 0 it returns zero.
- R8: The read outputs are registered. A select sampled at edge N is reflected after edge N, and the output does not change between edges when a select input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every operation happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Register number to write |
| wr_data | input | 16 | Word to write |
| rd1_sel | input | 3 | Register number for read port 1 (pre-write view) |
| rd2_sel | input | 3 | Register number for read port 2 (post-write view) |
| rd1_data | output | 16 | Registered read result of port 1 |
| rd2_data | output | 16 | Registered read result of port 2 |

## Verification
Several properties are checked by the assertions on every cycle:
- a zero select gives a zero output on the next cycle;
- reset clears both outputs;
- a committed write lands in the addressed slot;
- with writes disabled the storage stays unchanged;
- port 2 returns the write data on a same-cycle hit;
- port 1 never returns differing new data on a same-cycle hit.

Other behaviour only the bench scenarios can show:
- that a word written earlier comes back intact many cycles later;
- that reset wipes previously written contents;
- that outputs hold between edges while selects move;
- that the two ports differ as intended across long random mixes of hits, misses and register-0 traffic, each checked against a bench-side reference model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_NUM_REGS = 8;

  // Read-port view of a write landing at the same edge.
  typedef enum logic {
    VIEW_PRE_WRITE  = 1'b0,
    VIEW_POST_WRITE = 1'b1
  } read_view_e;
endpackage

// File: rtl/regbank_storage.sv
module regbank_storage
  import regbank_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_REGS = DEF_NUM_REGS,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  slots_q
);

  // A write is committed only when enabled and not aimed at the zero slot.
  function automatic logic commits(input logic en, input logic [ADDR_W-1:0] sel);
    return en && (sel != '0);
  endfunction

  logic write_commit;
  assign write_commit = commits(wr_en, wr_sel);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (i == 0) begin
        slots_q[i] <= '0;
      end else if (rst) begin
        slots_q[i] <= '0;
      end else if (write_commit && (wr_sel == ADDR_W'(i))) begin
        slots_q[i] <= wr_data;
      end
    end
  end

  // R1: a committed write lands in the addressed slot
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    write_commit |=> (slots_q[$past(wr_sel)] == $past(wr_data)));

  // R3: nothing moves while writes are disabled
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(slots_q[NUM_REGS-1:1]));

endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport
  import regbank_pkg::*;
#(
  parameter int         DATA_W = DEF_DATA_W,
  parameter int         ADDR_W = $clog2(DEF_NUM_REGS),
  parameter read_view_e VIEW   = VIEW_PRE_WRITE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_sel,
  input  logic [DATA_W-1:0] stored_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  function automatic logic same_edge_hit(input logic en,
                                         input logic [ADDR_W-1:0] ws,
                                         input logic [ADDR_W-1:0] rs);
    return en && (ws != '0) && (ws == rs);
  endfunction

  logic              hit;
  logic              sel_zero;
  logic [DATA_W-1:0] next_word;

  assign hit      = same_edge_hit(wr_en, wr_sel, rd_sel);
  assign sel_zero = (rd_sel == '0);

  generate
    if (VIEW == VIEW_POST_WRITE) begin : g_post
      assign next_word = hit ? wr_data : stored_word;

      // R6: post-write port returns the incoming data on a same-edge hit
      a_r6_forward_new: assert property (@(posedge clk) disable iff (rst)
        hit |=> (rd_data == $past(wr_data)));
    end else begin : g_pre
      assign next_word = stored_word;

      // R5: pre-write port never shows differing new data on a hit
      a_r5_keep_old: assert property (@(posedge clk) disable iff (rst)
        (hit && (wr_data != stored_word)) |=> (rd_data != $past(wr_data)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || sel_zero) rd_data <= '0;
    else                 rd_data <= next_word;
  end

  // R2: register 0 always reads zero
  a_r2_zero_slot: assert property (@(posedge clk) disable iff (rst)
    sel_zero |=> (rd_data == '0));

  // R4: reset clears the read output
  a_r4_reset_out: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

endmodule

// File: rtl/dual_read_regbank.sv
module dual_read_regbank
  import regbank_pkg::*;
#(
  parameter int  DATA_W   = DEF_DATA_W,
  parameter int  NUM_REGS = DEF_NUM_REGS,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd1_sel,
  input  logic [ADDR_W-1:0] rd2_sel,
  output logic [DATA_W-1:0] rd1_data,
  output logic [DATA_W-1:0] rd2_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0] slots;
  logic [DATA_W-1:0]               word1;
  logic [DATA_W-1:0]               word2;

  regbank_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_storage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slots_q(slots)
  );

  assign word1 = slots[rd1_sel];
  assign word2 = slots[rd2_sel];

  regbank_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VIEW(VIEW_PRE_WRITE)) u_port1 (
    .clk(clk), .rst(rst), .rd_sel(rd1_sel), .stored_word(word1),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd1_data)
  );

  regbank_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VIEW(VIEW_POST_WRITE)) u_port2 (
    .clk(clk), .rst(rst), .rd_sel(rd2_sel), .stored_word(word2),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd2_data)
  );

  // R7: no forwarding when the write is disabled and the word is unchanged
  a_r7_no_fwd_idle: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (rd2_sel == rd1_sel)) |=> (rd2_data == rd1_data));

endmodule

// File: tb/dual_read_regbank_bench.sv
`timescale 1ns/1ps
module dual_read_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd1_sel = '0;
  logic [2:0]  rd2_sel = '0;
  logic [15:0] rd1_data, rd2_data;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] model [8];

  always #2.5 clk = ~clk;

  dual_read_regbank u_dual_read_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd1_sel(rd1_sel), .rd2_sel(rd2_sel), .rd1_data(rd1_data), .rd2_data(rd2_data)
  );

  function automatic logic [15:0] pre_view(input logic [2:0] s);
    return (s == 3'd0) ? 16'h0 : model[s];
  endfunction

  function automatic logic [15:0] post_view(input logic [2:0] s, input logic we,
                                            input logic [2:0] ws, input logic [15:0] wd);
    if (s == 3'd0) return 16'h0;
    if (we && ws != 3'd0 && ws == s) return wd;
    return model[s];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag1(input logic we, input logic [2:0] ws, input logic [2:0] s);
    if (s == 3'd0) return "R2";
    if (we && ws != 3'd0 && ws == s) return "R5";
    if (!we) return "R3";
    return "R1";
  endfunction

  function automatic string tag2(input logic we, input logic [2:0] ws, input logic [2:0] s);
    if (s == 3'd0) return "R2";
    if (we && ws != 3'd0 && ws == s) return "R6";
    if (ws == s) return "R7";
    return "R1";
  endfunction

  // Called at a negedge: drive, compute expectations, cross posedge, compare.
  task automatic step(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                      input logic [2:0] s1, input logic [2:0] s2);
    logic [15:0] e1, e2;
    wr_en = we; wr_sel = ws; wr_data = wd; rd1_sel = s1; rd2_sel = s2;
    e1 = pre_view(s1);
    e2 = post_view(s2, we, ws, wd);
    if (we && ws != 3'd0) model[ws] = wd;
    @(posedge clk); #1;
    check(tag1(we, ws, s1), rd1_data, e1);
    check(tag2(we, ws, s2), rd2_data, e2);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rd1_sel = 3'd5; rd2_sel = 3'd6;
    @(posedge clk); #1;
    check("R4", rd1_data, 16'h0);
    check("R4", rd2_data, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();

    // R4: every register reads zero after reset
    for (int i = 0; i < 8; i++) step(1'b0, 3'd0, 16'h0, 3'(i), 3'(i));

    // R1: fill and read back
    for (int i = 1; i < 8; i++) step(1'b1, 3'(i), 16'h1110 * 16'(i) + 16'h3, 3'd0, 3'd0);
    for (int i = 0; i < 8; i++) step(1'b0, 3'd0, 16'h0, 3'(i), 3'(7 - i));

    // R2: write to register 0 ignored, forwarded as zero on port 2 (R7)
    step(1'b1, 3'd0, 16'hDEAD, 3'd0, 3'd0);
    step(1'b0, 3'd0, 16'h0, 3'd0, 3'd0);

    // R3: disabled write leaves register 3 alone
    step(1'b0, 3'd3, 16'hBEEF, 3'd3, 3'd3);
    step(1'b0, 3'd0, 16'h0, 3'd3, 3'd3);

    // R5 / R6: same-edge hit on both ports
    step(1'b1, 3'd4, 16'hA5A5, 3'd4, 3'd4);
    step(1'b0, 3'd0, 16'h0, 3'd4, 3'd4);
    step(1'b1, 3'd7, 16'hFFFF, 3'd7, 3'd2);

    // R8: output holds between edges while selects move
    begin
      logic [15:0] h1, h2;
      h1 = rd1_data; h2 = rd2_data;
      rd1_sel = 3'd1; rd2_sel = 3'd5;
      #1;
      check("R8", rd1_data, h1);
      check("R8", rd2_data, h2);
      @(negedge clk);
    end

    // Constrained random mix, biased toward hits
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ws, s1, s2;
      ws = 3'($urandom_range(0, 7));
      s1 = ($urandom_range(0, 3) == 0) ? ws : 3'($urandom_range(0, 7));
      s2 = ($urandom_range(0, 3) == 0) ? ws : 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), ws, 16'($urandom), s1, s2);
    end

    // R4: reset wipes previous contents
    do_reset();
    for (int i = 1; i < 8; i++) step(1'b0, 3'd0, 16'h0, 3'(i), 3'(i));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule